// File: doc/BRIEF.md
# Dual-Compare PWM Timer/Counter

An 8-bit timer/counter with two compare channels, A and B, that share one counter. Software writes the counter, the two compare registers and two control registers through a simple write port. Each count event moves the counter one step under one of four counting modes: free-running, clear-on-match, single-slope PWM and dual-slope (up/down) PWM. The count event comes either from a prescaler tick input or from an edge on an external pin, chosen by a control field. Each channel drives one waveform pin and raises its own match flag. A third flag marks counter overflow.

The direction of counting is held by a two-state machine. State `ST_UP` is the reset state and the only state used outside dual-slope mode. Transition `UP_TO_DOWN` is taken on a count event at TOP, and transition `DOWN_TO_UP` is taken on a count event at zero. Both transitions happen only in dual-slope mode. Leaving dual-slope mode forces `ST_UP`. In the PWM modes each compare register is double buffered: a write goes into a holding register, and the holding register is copied to the active compare value only at the cycle boundary of the current mode. A power-down input freezes the whole block.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, the counter reads 0, both waveform pins are 0, all three flags are 0 and the direction is up.
- R2: A write to address 0 loads the counter, 1 loads compare A and 2 loads compare B. Address 3 loads control 0: bits [1:0] select the mode, bit 2 selects TOP, bits [5:4] hold the output mode of A and bits [7:6] hold the output mode of B. Address 4 loads control 1, whose bits [1:0] select the clock source. Address 5 clears flags. A counter load wins over a count event in the same cycle; that event is dropped, with no flag and no buffer copy.
- R3: Clock source 0 stops the counter and 1 counts prescaler ticks. Source 2 counts rising edges of the external pin and 3 counts falling edges. The pin goes through a two-stage synchronizer, and the tick input is ignored under sources 2 and 3.
- R4: In mode 0 (free-running) the counter steps +1 and wraps from 0xFF to 0x00. In mode 1 (clear-on-match), a count event when the counter equals the active compare A value loads 0; otherwise the counter steps +1.
- R5: In mode 3 (dual-slope), TOP is set as in R6. A count event at TOP while up loads TOP-1 and turns down. A count event at 0 while down loads 1 and turns up. Any other event steps in the current direction.
- R6: In mode 2 (single-slope), TOP is 0xFF when control bit 2 is 0, and the active compare A value when it is 1. A count event at TOP loads 0.
- R7: In modes 0 and 1, a compare write updates the active value at once. In modes 2 and 3 it updates only the holding register. The holding register is copied to the active value on a count event at TOP: in mode 2 at the wrap, in mode 3 while counting up.
- R8: While power-down is 1, count events and all register writes are ignored, and the counter holds its value.
- R9: Flag bits at address 5 are bit 0 overflow, bit 1 match A and bit 2 match B; writing 1 to a bit clears that flag. Match x sets on a count event when the counter equals the active compare x. Overflow sets on an event at 0xFF in modes 0 and 1, on an event at TOP in mode 2, and on an event that takes a nonzero counter to 0 in mode 3. A set wins over a clear in the same cycle.
- R10: In modes 0 and 1, the 2-bit output mode of a channel acts on a match event. Code 0 disconnects the pin (output 0), 1 toggles it, 2 clears it and 3 sets it.
- R11: In modes 2 and 3, output mode codes 0 and 1 drive the pin to 0. In mode 2, code 2 sets the pin at the wrap and clears it on a match; code 3 does the inverse, and the wrap wins when both fall on one event. In mode 3, code 2 clears the pin on a match while counting up and sets it on a match while counting down; code 3 does the inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| tick | input | 1 | Prescaler count enable |
| ext_pin | input | 1 | External count pin |
| pwr_down | input | 1 | Freeze the block while 1 |
| cnt_q | output | 8 | Counter value |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| flag_ovf | output | 1 | Overflow flag |
| flag_cmp_a | output | 1 | Compare A match flag |
| flag_cmp_b | output | 1 | Compare B match flag |

## Verification
A wrong direction state shows up on `cnt_q` at the next count event, as a step the wrong way, since the counter value leaves the block directly. A stale or early active compare value shifts the cycle in which a match flag rises and a waveform pin changes, and this shows within one PWM period. In the TOP-from-compare mode it also moves the wrap point, and therefore the counter sequence itself. The bench compares the counter, both pins and all flags with a cycle model after every clock edge, so any divergence is reported in the cycle where it first reaches a port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_FREE  = 2'd0,
        MODE_CLEAR = 2'd1,
        MODE_FAST  = 2'd2,
        MODE_DUAL  = 2'd3
    } mode_e;

    typedef enum logic {
        ST_UP   = 1'b0,
        ST_DOWN = 1'b1
    } dir_e;

    localparam logic [2:0] ADR_CNT  = 3'd0;
    localparam logic [2:0] ADR_CMPA = 3'd1;
    localparam logic [2:0] ADR_CMPB = 3'd2;
    localparam logic [2:0] ADR_CTL0 = 3'd3;
    localparam logic [2:0] ADR_CTL1 = 3'd4;
    localparam logic [2:0] ADR_FCLR = 3'd5;

    localparam int CTL_W = 8;
    localparam int N_CH  = 2;
endpackage

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       ext_pin,
    input  logic [1:0] src,
    output logic       evt
);
    logic [SYNC:0] sh_q;
    logic          rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC-1:0], ext_pin};
    end

    assign rise = sh_q[SYNC-1] & ~sh_q[SYNC];
    assign fall = ~sh_q[SYNC-1] & sh_q[SYNC];

    always_comb begin
        unique case (src)
            2'd0: evt = 1'b0;
            2'd1: evt = tick;
            2'd2: evt = rise;
            2'd3: evt = fall;
        endcase
    end

    // R3: a source of 0 never produces a count event
    a_r3_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (src == 2'd0) |-> !evt);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic         pwr_down,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  mode_e        mode,
    input  logic         top_sel,
    input  logic [W-1:0] act_a,
    output logic [W-1:0] cnt,
    output logic         dir_up,
    output logic         evt_ok,
    output logic         upd_pt,
    output logic         ovf_set
);
    localparam logic [W-1:0] MAXV = '1;

    dir_e         state, state_n;
    logic [W-1:0] cnt_n, top_val;
    logic         pwm;

    assign pwm     = (mode == MODE_FAST) || (mode == MODE_DUAL);
    assign top_val = (pwm && top_sel) ? act_a : MAXV;
    assign evt_ok  = evt && !pwr_down && !cnt_wr;
    assign dir_up  = (state == ST_UP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            state <= ST_UP;
        else if (evt_ok || mode != MODE_DUAL)  state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (cnt_wr) cnt <= cnt_wdata;
        else if (evt_ok) cnt <= cnt_n;
    end

    // next state and step outputs
    always_comb begin
        state_n = ST_UP;
        cnt_n   = cnt + 1'b1;
        upd_pt  = 1'b0;
        ovf_set = 1'b0;
        unique case (mode)
            MODE_FREE: begin
                ovf_set = evt_ok && (cnt == MAXV);
            end
            MODE_CLEAR: begin
                if (cnt == act_a) cnt_n = '0;
                ovf_set = evt_ok && (cnt == MAXV);
            end
            MODE_FAST: begin
                if (cnt == top_val) begin
                    cnt_n   = '0;
                    upd_pt  = evt_ok;
                    ovf_set = evt_ok;
                end
            end
            MODE_DUAL: begin
                state_n = state;
                unique case (state)
                    ST_UP: begin
                        if (cnt == top_val) begin
                            upd_pt = evt_ok;
                            if (top_val != '0) begin
                                cnt_n   = cnt - 1'b1;
                                state_n = ST_DOWN;
                            end else begin
                                cnt_n = cnt;
                            end
                        end
                    end
                    ST_DOWN: begin
                        if (cnt == '0) state_n = ST_UP;
                        else           cnt_n   = cnt - 1'b1;
                    end
                endcase
                ovf_set = evt_ok && (cnt != '0) && (cnt_n == '0);
            end
        endcase
    end

    // R4: clear-on-match reloads zero after a match with compare A
    a_r4_clear_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ok && mode == MODE_CLEAR && cnt == act_a) |=> (cnt == '0));

    // R5: while counting down above zero, each event steps by minus one
    a_r5_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ok && mode == MODE_DUAL && state == ST_DOWN && cnt != '0)
        |=> (cnt == W'($past(cnt) - 1'b1)));

    // R8: counter frozen during power-down
    a_r8_pwr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> $stable(cnt));

    // R2: a load lands in the counter on the next cycle
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(cnt_wdata)));
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  mode_e        mode,
    input  logic [1:0]   com,
    input  logic         evt_ok,
    input  logic         upd_pt,
    input  logic         dir_up,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] act,
    output logic         match_set,
    output logic         wave
);
    logic [W-1:0] hold_q, act_q;
    logic         pin_q, pin_n, pwm, conn;

    assign pwm       = (mode == MODE_FAST) || (mode == MODE_DUAL);
    assign match_set = evt_ok && (cnt == act_q);
    assign act       = act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            act_q  <= '0;
            pin_q  <= 1'b0;
        end else begin
            if (cmp_wr) hold_q <= cmp_wdata;
            if (!pwm && cmp_wr)     act_q <= cmp_wdata;
            else if (pwm && upd_pt) act_q <= hold_q;
            pin_q <= pin_n;
        end
    end

    always_comb begin
        pin_n = pin_q;
        unique case (mode)
            MODE_FREE, MODE_CLEAR: begin
                if (match_set) begin
                    unique case (com)
                        2'd0: pin_n = pin_q;
                        2'd1: pin_n = ~pin_q;
                        2'd2: pin_n = 1'b0;
                        2'd3: pin_n = 1'b1;
                    endcase
                end
            end
            MODE_FAST: begin
                if (com[1]) begin
                    if (upd_pt)         pin_n = ~com[0];
                    else if (match_set) pin_n = com[0];
                end
            end
            MODE_DUAL: begin
                if (com[1] && match_set) pin_n = dir_up ? com[0] : ~com[0];
            end
        endcase
    end

    assign conn = pwm ? com[1] : (com != 2'd0);
    assign wave = pin_q & conn;

    // R7: in PWM modes the active value only moves at the update point
    a_r7_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !upd_pt) |=> $stable(act_q));

    // R10: clear-on-match output code drives the pin low after a match
    a_r10_clear_out: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm && com == 2'd2 && match_set) |=> !pin_q);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import tmr_pkg::*;
#(
    parameter int W    = 8,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         tick,
    input  logic         ext_pin,
    input  logic         pwr_down,
    output logic [W-1:0] cnt_q,
    output logic         wave_a,
    output logic         wave_b,
    output logic         flag_ovf,
    output logic         flag_cmp_a,
    output logic         flag_cmp_b
);
    logic [CTL_W-1:0] ctl0_q;
    logic [1:0]       src_q;
    logic             wr_ok, evt, evt_ok, upd_pt, ovf_set, dir_up;
    logic [2:0]       clr;
    logic [W-1:0]     act   [N_CH];
    logic [N_CH-1:0]  mset, wave, cwr;
    mode_e            mode;

    assign wr_ok = wr_en && !pwr_down;
    assign mode  = mode_e'(ctl0_q[1:0]);
    assign clr   = (wr_ok && wr_addr == ADR_FCLR) ? wr_data[2:0] : 3'b000;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl0_q <= '0;
            src_q  <= '0;
        end else begin
            if (wr_ok && wr_addr == ADR_CTL0) ctl0_q <= wr_data[CTL_W-1:0];
            if (wr_ok && wr_addr == ADR_CTL1) src_q  <= wr_data[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_ovf   <= 1'b0;
            flag_cmp_a <= 1'b0;
            flag_cmp_b <= 1'b0;
        end else begin
            flag_ovf   <= (flag_ovf   & ~clr[0]) | ovf_set;
            flag_cmp_a <= (flag_cmp_a & ~clr[1]) | mset[0];
            flag_cmp_b <= (flag_cmp_b & ~clr[2]) | mset[1];
        end
    end

    tmr_clk_sel #(.SYNC(SYNC)) u_clk (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ext_pin(ext_pin),
        .src(src_q), .evt(evt)
    );

    tmr_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .evt(evt), .pwr_down(pwr_down),
        .cnt_wr(wr_ok && wr_addr == ADR_CNT), .cnt_wdata(wr_data),
        .mode(mode), .top_sel(ctl0_q[2]), .act_a(act[0]),
        .cnt(cnt_q), .dir_up(dir_up), .evt_ok(evt_ok),
        .upd_pt(upd_pt), .ovf_set(ovf_set)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        assign cwr[i] = wr_ok && (wr_addr == 3'(i + 1));
        tmr_cmp_chan #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .cmp_wr(cwr[i]), .cmp_wdata(wr_data),
            .mode(mode), .com(ctl0_q[4+2*i +: 2]), .evt_ok(evt_ok),
            .upd_pt(upd_pt), .dir_up(dir_up), .cnt(cnt_q),
            .act(act[i]), .match_set(mset[i]), .wave(wave[i])
        );
    end

    assign wave_a = wave[0];
    assign wave_b = wave[1];

    // R9: a clear without a coincident set empties the overflow flag
    a_r9_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[0] && !ovf_set) |=> !flag_ovf);

    // R9: a set event always leaves the flag high
    a_r9_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> flag_ovf);
endmodule

// File: tb/sim_dual_cmp_timer.sv
`timescale 1ns/1ps
module sim_dual_cmp_timer;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, tick = 1'b0, ext_pin = 1'b0, pwr_down = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] cnt_q;
    logic wave_a, wave_b, flag_ovf, flag_cmp_a, flag_cmp_b;

    always #2 clk = ~clk;

    dual_cmp_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .ext_pin(ext_pin),
        .pwr_down(pwr_down), .cnt_q(cnt_q), .wave_a(wave_a),
        .wave_b(wave_b), .flag_ovf(flag_ovf), .flag_cmp_a(flag_cmp_a),
        .flag_cmp_b(flag_cmp_b)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_cnt, m_c0, m_c1;
    logic       m_up;
    logic [7:0] m_act [2];
    logic [7:0] m_hold [2];
    logic [1:0] m_pin;
    logic [2:0] m_fl;

    task automatic chk(input string tag, input int act_v, input int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_c0 = 0; m_c1 = 0; m_up = 1'b1;
        m_act[0] = 0; m_act[1] = 0; m_hold[0] = 0; m_hold[1] = 0;
        m_pin = 0; m_fl = 0;
    endtask

    task automatic model_step(input logic t, input logic we, input logic [2:0] a,
                              input logic [7:0] d, input logic pd);
        logic [1:0] mode, com;
        logic tsel, pwm, wok, cw, ev, ovf, upd, nup;
        logic [7:0] top, nxt;
        logic [1:0] mt;
        logic [2:0] clr;
        mode = m_c0[1:0]; tsel = m_c0[2]; pwm = mode[1];
        wok = we && !pd;
        cw = wok && (a == 3'd0);
        ev = t && (m_c1[1:0] == 2'd1) && !pd && !cw;
        top = (pwm && tsel) ? m_act[0] : 8'hFF;
        nxt = m_cnt + 8'd1; nup = 1'b1; upd = 1'b0; ovf = 1'b0;
        case (mode)
            2'd0: ovf = ev && (m_cnt == 8'hFF);
            2'd1: begin
                if (m_cnt == m_act[0]) nxt = 8'd0;
                ovf = ev && (m_cnt == 8'hFF);
            end
            2'd2: if (m_cnt == top) begin nxt = 8'd0; upd = ev; ovf = ev; end
            default: begin
                nup = m_up;
                if (m_up) begin
                    if (m_cnt == top) begin
                        upd = ev;
                        if (top != 8'd0) begin nxt = m_cnt - 8'd1; nup = 1'b0; end
                        else nxt = m_cnt;
                    end
                end else begin
                    if (m_cnt == 8'd0) begin nxt = 8'd1; nup = 1'b1; end
                    else nxt = m_cnt - 8'd1;
                end
                ovf = ev && (m_cnt != 8'd0) && (nxt == 8'd0);
            end
        endcase
        for (int i = 0; i < 2; i++) begin
            mt[i] = ev && (m_cnt == m_act[i]);
            com = m_c0[4+2*i +: 2];
            if (!pwm) begin
                if (mt[i]) case (com)
                    2'd1: m_pin[i] = ~m_pin[i];
                    2'd2: m_pin[i] = 1'b0;
                    2'd3: m_pin[i] = 1'b1;
                    default: ;
                endcase
            end else if (mode == 2'd2) begin
                if (com[1]) begin
                    if (upd) m_pin[i] = ~com[0];
                    else if (mt[i]) m_pin[i] = com[0];
                end
            end else begin
                if (com[1] && mt[i]) m_pin[i] = m_up ? com[0] : ~com[0];
            end
        end
        for (int i = 0; i < 2; i++) begin
            if (pwm) begin
                if (upd) m_act[i] = m_hold[i];
            end else if (wok && a == 3'(i + 1)) m_act[i] = d;
            if (wok && a == 3'(i + 1)) m_hold[i] = d;
        end
        clr = (wok && a == 3'd5) ? d[2:0] : 3'b000;
        m_fl = (m_fl & ~clr) | {mt[1], mt[0], ovf};
        if (mode != 2'd3) m_up = 1'b1;
        else if (ev) m_up = nup;
        if (cw) m_cnt = d;
        else if (ev) m_cnt = nxt;
        if (wok && a == 3'd3) m_c0 = d;
        if (wok && a == 3'd4) m_c1 = {6'd0, d[1:0]};
    endtask

    task automatic compare_all();
        string ct, wt;
        logic [1:0] com;
        logic [1:0] ew;
        case (m_c0[1:0])
            2'd0, 2'd1: begin ct = "R4 count"; wt = "R10 wave"; end
            2'd2:       begin ct = "R6 count"; wt = "R11 wave"; end
            default:    begin ct = "R5 count"; wt = "R11 wave"; end
        endcase
        for (int i = 0; i < 2; i++) begin
            com = m_c0[4+2*i +: 2];
            ew[i] = m_pin[i] & (m_c0[1] ? com[1] : (com != 2'd0));
        end
        chk(ct, cnt_q, m_cnt);
        chk(wt, {wave_b, wave_a}, ew);
        chk("R9 flags", {flag_cmp_b, flag_cmp_a, flag_ovf}, m_fl);
    endtask

    task automatic cyc(input logic t, input logic we, input logic [2:0] a,
                       input logic [7:0] d, input logic pd);
        tick = t; wr_en = we; wr_addr = a; wr_data = d; pwr_down = pd; ext_pin = 1'b0;
        @(posedge clk);
        model_step(t, we, a, d, pd);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1'b0, 1'b1, a, d, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 3'd0, 8'd0, 1'b0);
    endtask

    task automatic rawcyc(input logic t, input logic we, input logic [2:0] a,
                          input logic [7:0] d, input logic ex);
        tick = t; wr_en = we; wr_addr = a; wr_data = d; pwr_down = 1'b0; ext_pin = ex;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic t, we, pd;
        logic [2:0] a;
        logic [7:0] d;
        seed = $urandom(32'd24681);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cnt", cnt_q, 0);
        chk("R1 waves", {wave_b, wave_a}, 0);
        chk("R1 flags", {flag_cmp_b, flag_cmp_a, flag_ovf}, 0);

        // R2 load and precedence over a count event
        wr(3'd0, 8'h5A);
        chk("R2 load", cnt_q, 8'h5A);
        wr(3'd4, 8'h01);
        cyc(1'b1, 1'b1, 3'd0, 8'h10, 1'b0);
        chk("R2 load wins", cnt_q, 8'h10);

        // R8 power-down ignores writes and ticks
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'b1, 3'd0, 8'h77, 1'b1);
        chk("R8 frozen", cnt_q, 8'h10);

        // R4 wrap and R9 overflow set / clear
        wr(3'd0, 8'hFF);
        ticks(1);
        chk("R4 wrap", cnt_q, 0);
        chk("R9 ovf set", flag_ovf, 1);
        wr(3'd5, 8'h01);
        chk("R9 ovf clear", flag_ovf, 0);

        // R4 clear-on-match period
        wr(3'd3, 8'h01);
        wr(3'd1, 8'd3);
        wr(3'd0, 8'd0);
        ticks(4);
        chk("R4 reload", cnt_q, 0);
        chk("R9 match A", flag_cmp_a, 1);

        // R7 deferred compare write in single-slope mode, TOP from compare A
        wr(3'd3, 8'h00);
        wr(3'd1, 8'd50);
        wr(3'd0, 8'd10);
        wr(3'd3, 8'h06);
        wr(3'd1, 8'd20);
        ticks(15);
        chk("R7 deferred", cnt_q, 25);
        ticks(26);
        chk("R6 wrap at TOP", cnt_q, 0);

        // R5 turn-around at TOP
        wr(3'd3, 8'h03);
        wr(3'd0, 8'hFE);
        ticks(2);
        chk("R5 turn down", cnt_q, 8'hFE);
        ticks(1);
        chk("R5 step down", cnt_q, 8'hFD);

        // random phases per mode
        for (int md = 0; md < 4; md++) begin
            wr(3'd3, {6'($urandom), 2'(md)});
            wr(3'd4, 8'h01);
            for (int n = 0; n < 2500; n++) begin
                t = 1'($urandom % 2);
                we = (($urandom % 16) == 0);
                pd = (($urandom % 64) == 0);
                case ($urandom % 6)
                    0: a = 3'd0;
                    1: a = 3'd1;
                    2: a = 3'd2;
                    3: a = 3'd3;
                    4: a = 3'd5;
                    default: a = 3'd4;
                endcase
                d = 8'($urandom);
                if (a == 3'd3) d = {d[7:2], 2'(md)};
                if (a == 3'd4) d = (($urandom % 4) == 0) ? 8'h00 : 8'h01;
                cyc(t, we, a, d, pd);
            end
        end

        // R3 external pin sources (model not used from here)
        rawcyc(1'b0, 1'b1, 3'd3, 8'h00, 1'b0);
        rawcyc(1'b0, 1'b1, 3'd0, 8'h00, 1'b0);
        rawcyc(1'b0, 1'b1, 3'd4, 8'h02, 1'b0);
        for (int p = 0; p < 5; p++) begin
            repeat (4) rawcyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b1);
            repeat (4) rawcyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b0);
        end
        repeat (4) rawcyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b0);
        chk("R3 rising edges", cnt_q, 5);
        rawcyc(1'b0, 1'b1, 3'd4, 8'h03, 1'b0);
        for (int p = 0; p < 5; p++) begin
            repeat (4) rawcyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b1);
            repeat (4) rawcyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b0);
        end
        repeat (4) rawcyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b0);
        chk("R3 falling edges", cnt_q, 10);
        rawcyc(1'b0, 1'b1, 3'd4, 8'h00, 1'b0);
        repeat (10) rawcyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b0);
        chk("R3 stopped", cnt_q, 10);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule